// File: doc/BRIEF.md
# Layered Write-Protection Gate

This block sits between the serial-bus front end of a small byte-addressed nonvolatile memory and its program logic. It decides whether each control byte is answered with an acknowledge. For every data byte of a write transaction it decides whether that byte may actually be committed to the array. Three protection sources feed the decision: a hardware protect input, a permanent software flag that can never be cleared, and a reversible software flag. Together they produce three protection extents: nothing, the lower half of the address space, or the whole array.

The front end reports bus events as single-cycle strobes: a decoded control byte, a word-address byte, each data byte, and a valid stop. The gate never stalls these events, so there is no ready signal and no back-pressure. Every strobe is taken on the clock edge where it is high. The acknowledge and the byte write enable are combinational answers to the strobe present in the same cycle. Protection state is reported only by acknowledging or withholding the acknowledge on special commands. A stop that ends a write with at least one data byte starts a timed write cycle. During that cycle the gate acknowledges nothing. Flag changes requested by a special command take effect when the cycle ends. The flags are held in registers that a power-on reset clears and a soft reset keeps.

Top module: `prot_gate`

## Requirements
- R1: While `hw_wp` is high, `byte_we` stays low for every address. Control bytes with code 1010 are still acknowledged for both read and write.
- R2: While `hw_wp` is low and either software flag is set, data bytes whose pointer is below 80h give `byte_we` low, and those at 80h or above give `byte_we` high.
- R3: A write whose data bytes are blocked is still acknowledged. Its stop still raises `busy` for exactly `WR_CYCLES` cycles. No control byte is acknowledged while `busy` is high.
- R4: Control code 0110 with the read/write bit low (write) and `a0_hv` low sets the permanent flag. After that, every control byte with code 0110 is refused. The flag survives `soft_rst` and is cleared only by `por_n`.
- R5: Code 0110, write, with `a0_hv` high and select bits 001 (control byte 62h) sets the reversible flag; it is acknowledged only while that flag is clear. With select bits 011 (66h) it clears the flag.
- R6: Code 0110 with the read/write bit high is a status query. With `a0_hv` low it asks about the permanent flag; with `a0_hv` high it asks about the reversible flag. The query is acknowledged when the asked flag is clear and refused when it is set.
- R7: With `hw_wp` high at the stop, set and clear commands are acknowledged and run a write cycle, but leave both flags unchanged.
- R8: A clear of the reversible flag is refused while the permanent flag is set.
- R9: In an array write, the first data byte goes to the received word address. After each data byte only the low `PAGE_W` pointer bits increment, wrapping within the page, so that 7Eh, 7Fh is followed by 70h.
- R10: Flag changes appear only at the cycle where the write cycle ends. The first control byte after `busy` falls already sees the new state.
- R11: Control codes other than 1010, 1011 and 0110 are refused. A write with code 1011 is acknowledged and loads the pointer, but never raises `byte_we` and starts no write cycle.
- R12: `soft_rst` drops any open transaction, ends a running write cycle without applying its flag change, and returns the pointer to 0. Both flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including the flags |
| soft_rst | input | 1 | Synchronous soft reset that keeps the flags |
| hw_wp | input | 1 | Hardware protect level for the whole array |
| ctl_valid | input | 1 | Strobe: decoded control byte present |
| ctl_code | input | 4 | Upper four bits of the control byte |
| ctl_rd | input | 1 | Read/write bit of the control byte (1 = read) |
| ctl_sel | input | 3 | Three select bits of the control byte |
| a0_hv | input | 1 | High-voltage qualifier seen on the A0 strap |
| ctl_ack | output | 1 | Acknowledge decision for the control byte in this cycle |
| word_valid | input | 1 | Strobe: word-address byte present |
| word_addr | input | ADDR_W | Word-address byte |
| data_valid | input | 1 | Strobe: data byte present |
| byte_we | output | 1 | Commit this data byte to the array |
| byte_addr | output | ADDR_W | Array address of this data byte |
| stop | input | 1 | Strobe: valid stop condition |
| busy | output | 1 | Timed write cycle in progress |

## Verification
The bench focuses on a few corner cases. It checks the 7Fh/80h boundary under software protection; a design with the wrong half, or the wrong compare width, commits lower-half bytes. It checks a page write that runs past the end of its page; a design that carries into the page bits writes 80h instead of 70h. It checks blocked writes, where a design that drops the acknowledge or skips the timed cycle would disagree with the bus master's acknowledge polling. It also checks special commands under `hw_wp`, a soft reset in the middle of a cycle, and refusals once the permanent flag is set. In each of these, a design that updates a flag too early, too eagerly, or not at all shows up as a wrong acknowledge on the next status query.

// File: rtl/prot_gate_pkg.sv
package prot_gate_pkg;

  typedef enum logic [2:0] {
    SK_NONE,
    SK_ARR_WR,
    SK_READ,
    SK_EXT_WR,
    SK_PROT_WR
  } sess_kind_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_SET_PERM,
    OP_SET_REV,
    OP_CLR_REV
  } prot_op_e;

  localparam logic [3:0] CODE_ARRAY = 4'hA;
  localparam logic [3:0] CODE_EXT   = 4'hB;
  localparam logic [3:0] CODE_PROT  = 4'h6;

  localparam logic [2:0] SEL_SET_REV = 3'b001;
  localparam logic [2:0] SEL_CLR_REV = 3'b011;

endpackage

// File: rtl/prot_cmd_decode.sv
module prot_cmd_decode
  import prot_gate_pkg::*;
(
  input  logic       busy,
  input  logic       perm,
  input  logic       rev,
  input  logic [3:0] code,
  input  logic       rd,
  input  logic [2:0] sel,
  input  logic       hv,
  output logic       ack,
  output sess_kind_e kind,
  output prot_op_e   op
);

  logic       raw_ack;
  sess_kind_e raw_kind;
  prot_op_e   raw_op;

  always_comb begin
    raw_ack  = 1'b0;
    raw_kind = SK_NONE;
    raw_op   = OP_NONE;
    unique case (code)
      CODE_ARRAY: begin
        raw_ack  = 1'b1;
        raw_kind = rd ? SK_READ : SK_ARR_WR;
      end
      CODE_EXT: begin
        raw_ack  = 1'b1;
        raw_kind = rd ? SK_READ : SK_EXT_WR;
      end
      CODE_PROT: begin
        if (!perm) begin
          if (rd) begin
            raw_ack  = hv ? !rev : 1'b1;
            raw_kind = SK_READ;
          end else if (!hv) begin
            raw_ack  = 1'b1;
            raw_kind = SK_PROT_WR;
            raw_op   = OP_SET_PERM;
          end else if (sel == SEL_SET_REV) begin
            raw_ack  = !rev;
            raw_kind = SK_PROT_WR;
            raw_op   = OP_SET_REV;
          end else if (sel == SEL_CLR_REV) begin
            raw_ack  = 1'b1;
            raw_kind = SK_PROT_WR;
            raw_op   = OP_CLR_REV;
          end
        end
      end
      default: ;
    endcase
  end

  assign ack  = raw_ack && !busy;
  assign kind = ack ? raw_kind : SK_NONE;
  assign op   = ack ? raw_op : OP_NONE;

endmodule

// File: rtl/prot_flags.sv
module prot_flags
  import prot_gate_pkg::*;
(
  input  logic     clk,
  input  logic     por_n,
  input  logic     apply,
  input  prot_op_e op,
  output logic     perm,
  output logic     rev
);

  logic perm_q, rev_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      perm_q <= 1'b0;
      rev_q  <= 1'b0;
    end else if (apply) begin
      unique case (op)
        OP_SET_PERM: perm_q <= 1'b1;
        OP_SET_REV:  rev_q  <= 1'b1;
        OP_CLR_REV:  rev_q  <= 1'b0;
        default: ;
      endcase
    end
  end

  assign perm = perm_q;
  assign rev  = rev_q;

  // R4
  perm_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    perm_q |=> perm_q);

  // R10
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    !apply |=> $stable({perm_q, rev_q}));

endmodule

// File: rtl/prot_wr_timer.sv
module prot_wr_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic por_n,
  input  logic soft_rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (soft_rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0) && !soft_rst;

  // R3
  timer_launch_chk: assert property (@(posedge clk) disable iff (!por_n)
    (start && !busy_q && !soft_rst) |=> busy_q);

endmodule

// File: rtl/prot_gate.sv
module prot_gate
  import prot_gate_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst,
  input  logic              hw_wp,
  input  logic              ctl_valid,
  input  logic [3:0]        ctl_code,
  input  logic              ctl_rd,
  input  logic [2:0]        ctl_sel,
  input  logic              a0_hv,
  output logic              ctl_ack,
  input  logic              word_valid,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              data_valid,
  output logic              byte_we,
  output logic [ADDR_W-1:0] byte_addr,
  input  logic              stop,
  output logic              busy
);

  logic       perm_w, rev_w, wc_busy, wc_done, dec_ack;
  sess_kind_e dec_kind, kind_q;
  prot_op_e   dec_op, op_q, pend_q;
  logic       word_seen_q, data_seen_q;
  logic [ADDR_W-1:0] ptr_q, ptr_step;
  logic       is_write, cycle_start, sw_any, allow;

  prot_cmd_decode u_dec (
    .busy(wc_busy), .perm(perm_w), .rev(rev_w),
    .code(ctl_code), .rd(ctl_rd), .sel(ctl_sel), .hv(a0_hv),
    .ack(dec_ack), .kind(dec_kind), .op(dec_op)
  );

  prot_flags u_flags (
    .clk(clk), .por_n(por_n), .apply(wc_done), .op(pend_q),
    .perm(perm_w), .rev(rev_w)
  );

  prot_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .start(cycle_start),
    .busy(wc_busy), .done(wc_done)
  );

  generate
    if (PAGE_W < ADDR_W) begin : g_paged
      assign ptr_step = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
    end else begin : g_flat
      assign ptr_step = ptr_q + 1'b1;
    end
  endgenerate

  assign is_write    = (kind_q == SK_ARR_WR) || (kind_q == SK_EXT_WR) ||
                       (kind_q == SK_PROT_WR);
  assign cycle_start = stop && !ctl_valid && !word_valid && !data_valid &&
                       data_seen_q && !wc_busy &&
                       ((kind_q == SK_ARR_WR) || (kind_q == SK_PROT_WR));
  assign sw_any      = perm_w || rev_w;
  assign allow       = !hw_wp && !(sw_any && !ptr_q[ADDR_W-1]);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      kind_q <= SK_NONE; op_q <= OP_NONE; pend_q <= OP_NONE;
      word_seen_q <= 1'b0; data_seen_q <= 1'b0; ptr_q <= '0;
    end else if (soft_rst) begin
      kind_q <= SK_NONE; op_q <= OP_NONE; pend_q <= OP_NONE;
      word_seen_q <= 1'b0; data_seen_q <= 1'b0; ptr_q <= '0;
    end else begin
      if (wc_done) pend_q <= OP_NONE;
      if (ctl_valid) begin
        kind_q      <= dec_kind;
        op_q        <= dec_op;
        word_seen_q <= 1'b0;
        data_seen_q <= 1'b0;
      end else if (word_valid) begin
        if (is_write && !word_seen_q) begin
          word_seen_q <= 1'b1;
          if (kind_q != SK_PROT_WR) ptr_q <= word_addr;
        end
      end else if (data_valid) begin
        if (is_write && word_seen_q) begin
          data_seen_q <= 1'b1;
          if (kind_q == SK_ARR_WR) ptr_q <= ptr_step;
        end
      end else if (stop) begin
        kind_q      <= SK_NONE;
        op_q        <= OP_NONE;
        word_seen_q <= 1'b0;
        data_seen_q <= 1'b0;
        if (cycle_start)
          pend_q <= ((kind_q == SK_PROT_WR) && !hw_wp) ? op_q : OP_NONE;
      end
    end
  end

  assign ctl_ack   = ctl_valid && dec_ack;
  assign byte_we   = data_valid && !ctl_valid && !word_valid && word_seen_q &&
                     (kind_q == SK_ARR_WR) && allow;
  assign byte_addr = ptr_q;
  assign busy      = wc_busy;

  // R1
  hw_block_chk: assert property (@(posedge clk) disable iff (!por_n)
    hw_wp |-> !byte_we);

  // R2
  lower_half_chk: assert property (@(posedge clk) disable iff (!por_n)
    (byte_we && (perm_w || rev_w)) |-> byte_addr[ADDR_W-1]);

  // R3
  busy_nack_chk: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> !ctl_ack);

  // R12
  soft_rst_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> (!busy && !byte_we));

endmodule

// File: tb/prot_gate_bench.sv
module prot_gate_bench;

  localparam int WRC = 40;

  logic clk = 1'b0, por_n = 1'b0, soft_rst = 1'b0, hw_wp = 1'b0;
  logic ctl_valid = 1'b0, ctl_rd = 1'b0, a0_hv = 1'b0;
  logic [3:0] ctl_code = 4'h0;
  logic [2:0] ctl_sel = 3'h0;
  logic word_valid = 1'b0, data_valid = 1'b0, stop = 1'b0;
  logic [7:0] word_addr = 8'h0;
  logic ctl_ack, byte_we, busy;
  logic [7:0] byte_addr;

  always #4 clk = ~clk;

  prot_gate #(.ADDR_W(8), .PAGE_W(4), .WR_CYCLES(WRC)) u_prot_gate (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .hw_wp(hw_wp),
    .ctl_valid(ctl_valid), .ctl_code(ctl_code), .ctl_rd(ctl_rd),
    .ctl_sel(ctl_sel), .a0_hv(a0_hv), .ctl_ack(ctl_ack),
    .word_valid(word_valid), .word_addr(word_addr),
    .data_valid(data_valid), .byte_we(byte_we), .byte_addr(byte_addr),
    .stop(stop), .busy(busy)
  );

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;
  // model: kind 0 none, 1 array wr, 2 read, 3 ext wr, 4 prot wr
  // op 0 none, 1 set perm, 2 set rev, 3 clear rev
  bit m_perm = 0, m_rev = 0, m_word = 0, m_data = 0;
  int m_kind = 0, m_op = 0;
  logic [7:0] m_ptr = 8'h0;
  bit last_ack;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_kind(input logic [3:0] c, input bit rd,
                                  input logic [2:0] s, input bit hv);
    if (c == 4'hA) return rd ? 2 : 1;
    if (c == 4'hB) return rd ? 2 : 3;
    if (c == 4'h6 && !m_perm) begin
      if (rd) return (hv && m_rev) ? 0 : 2;
      if (!hv) return 4;
      if (s == 3'b001) return m_rev ? 0 : 4;
      if (s == 3'b011) return 4;
    end
    return 0;
  endfunction

  function automatic int exp_op(input bit rd, input logic [2:0] s, input bit hv);
    if (rd) return 0;
    if (!hv) return 1;
    return (s == 3'b001) ? 2 : 3;
  endfunction

  task automatic ctl(input logic [3:0] c, input bit rd, input logic [2:0] s,
                     input bit hv, input string req);
    int k;
    k = exp_kind(c, rd, s, hv);
    @(negedge clk);
    ctl_valid = 1; ctl_code = c; ctl_rd = rd; ctl_sel = s; a0_hv = hv;
    #1;
    last_ack = ctl_ack;
    chk(ctl_ack == (k != 0), req, ctl_ack, k != 0);
    @(posedge clk); #1;
    ctl_valid = 0; a0_hv = 0;
    m_kind = k; m_op = (k == 4) ? exp_op(rd, s, hv) : 0;
    m_word = 0; m_data = 0;
  endtask

  task automatic word(input logic [7:0] a);
    @(negedge clk);
    word_valid = 1; word_addr = a;
    @(posedge clk); #1;
    word_valid = 0;
    if ((m_kind == 1 || m_kind == 3 || m_kind == 4) && !m_word) begin
      m_word = 1;
      if (m_kind != 4) m_ptr = a;
    end
  endtask

  task automatic data(input string req);
    bit e;
    e = (m_kind == 1) && m_word && !hw_wp && !(m_ptr < 8'h80 && (m_perm || m_rev));
    @(negedge clk);
    data_valid = 1;
    #1;
    chk(byte_we == e, req, byte_we, e);
    if (e) chk(byte_addr == m_ptr, {req, " addr"}, byte_addr, m_ptr);
    @(posedge clk); #1;
    data_valid = 0;
    if (m_word && (m_kind == 1 || m_kind == 3 || m_kind == 4)) begin
      m_data = 1;
      if (m_kind == 1) m_ptr = {m_ptr[7:4], m_ptr[3:0] + 4'h1};
    end
  endtask

  task automatic stopc(input string req);
    bit st;
    int pop, n;
    st  = m_data && (m_kind == 1 || m_kind == 4);
    pop = (m_kind == 4 && !hw_wp) ? m_op : 0;
    @(negedge clk);
    stop = 1;
    @(posedge clk); #1;
    stop = 0;
    m_kind = 0; m_op = 0; m_word = 0; m_data = 0;
    if (st) begin
      n = 0;
      while (busy && n < 1000) begin n++; @(posedge clk); #1; end
      chk(n == WRC, {req, " busy length"}, n, WRC);
      if (pop == 1) m_perm = 1;
      if (pop == 2) m_rev = 1;
      if (pop == 3) m_rev = 0;
    end else begin
      chk(busy == 0, {req, " no cycle"}, busy, 0);
    end
  endtask

  task automatic prot_cmd(input logic [2:0] s, input bit hv, input string req);
    ctl(4'h6, 0, s, hv, req);
    word(8'h5A);
    data(req);
    stopc(req);
  endtask

  task automatic arr_write(input logic [7:0] a, input int len, input string req);
    ctl(4'hA, 0, 3'b000, 0, req);
    word(a);
    for (int i = 0; i < len; i++) data(req);
    stopc(req);
  endtask

  task automatic query(input bit hv, input string req);
    ctl(4'h6, 1, 3'b000, hv, req);
    stopc(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 0 && byte_we == 0 && ctl_ack == 0, "reset state", busy, 0);
    @(negedge clk); por_n = 1;

    // R9 page wrap, all writable
    arr_write(8'h7E, 3, "R9 wrap");
    query(0, "R6 perm clear");
    query(1, "R6 rev clear");

    // R7 commands under hw protect change nothing
    hw_wp = 1;
    prot_cmd(3'b001, 1, "R7 set rev hw");
    query(1, "R7 rev still clear");
    // R1 no writes under hw protect, control still acked
    arr_write(8'h85, 2, "R1 hw block");
    ctl(4'hA, 1, 3'b000, 0, "R1 read acked"); stopc("R1");
    hw_wp = 0;

    // R5 set reversible, R10 visible right after cycle
    prot_cmd(3'b001, 1, "R5 set rev");
    query(1, "R10 rev now set");
    prot_cmd(3'b001, 1, "R5 set again refused");
    arr_write(8'h7F, 1, "R2 lower blocked");
    arr_write(8'h80, 2, "R2 upper written");
    arr_write(8'h10, 1, "R3 blocked still cycles");
    // R3 no ack while busy
    ctl(4'hA, 0, 3'b000, 0, "R3"); word(8'h20); data("R3");
    @(negedge clk); stop = 1; @(posedge clk); #1; stop = 0;
    m_kind = 0; m_word = 0; m_data = 0;
    @(negedge clk); ctl_valid = 1; ctl_code = 4'hA; ctl_rd = 1; #1;
    chk(ctl_ack == 0 && busy == 1, "R3 nack while busy", ctl_ack, 0);
    @(posedge clk); #1; ctl_valid = 0;
    while (busy) @(posedge clk);
    #1;

    // R12 soft reset keeps flags
    @(negedge clk); soft_rst = 1; @(posedge clk); #1; soft_rst = 0; m_ptr = 0;
    query(1, "R12 rev kept");
    // R5 clear
    prot_cmd(3'b011, 1, "R5 clear rev");
    query(1, "R5 rev cleared");
    // R12 soft reset mid cycle drops pending set
    ctl(4'h6, 0, 3'b001, 1, "R12"); word(8'h00); data("R12");
    @(negedge clk); stop = 1; @(posedge clk); #1; stop = 0;
    m_kind = 0; m_word = 0; m_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); soft_rst = 1; @(posedge clk); #1; soft_rst = 0; m_ptr = 0;
    chk(busy == 0, "R12 cycle ended", busy, 0);
    query(1, "R12 pending dropped");

    // R11 other codes, extended-block write
    ctl(4'h3, 0, 3'b000, 0, "R11 bad code"); stopc("R11");
    ctl(4'hB, 0, 3'b000, 0, "R11 ext write");
    word(8'h90); data("R11 ext no we"); stopc("R11 ext");

    // random mix
    for (int it = 0; it < 80; it++) begin
      int r;
      hw_wp = (($urandom % 4) == 0);
      r = $urandom % 6;
      case (r)
        0, 1, 2: arr_write(8'($urandom), 1 + ($urandom % 18), "R2 random write");
        3: prot_cmd(3'b001, 1, "R5 random set");
        4: prot_cmd(3'b011, 1, "R5 random clear");
        default: query($urandom % 2, "R6 random query");
      endcase
    end
    hw_wp = 0;

    // R4 permanent flag
    prot_cmd(3'b000, 0, "R4 set perm");
    query(0, "R4 perm query refused");
    query(1, "R4 rev query refused");
    prot_cmd(3'b011, 1, "R8 clear refused");
    prot_cmd(3'b001, 1, "R4 set rev refused");
    arr_write(8'h22, 1, "R4 lower blocked");
    arr_write(8'hA2, 1, "R4 upper open");
    @(negedge clk); soft_rst = 1; @(posedge clk); #1; soft_rst = 0; m_ptr = 0;
    query(0, "R4 perm survives soft reset");
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
    m_perm = 0; m_rev = 0; m_ptr = 0;
    query(0, "R4 por clears perm");
    arr_write(8'h05, 1, "R4 lower open after por");

    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule